// File: doc/BRIEF.md
# Periodic Tick Timer with Interrupt

The block produces a steady periodic interrupt from a programmable down-counter. A period register holds the reload value. Two separate control commands manage the counter. One command copies the period into the counter. The other sets the counter running. The running counter steps down once per clock. When it would step down to zero, it reloads from the period register and latches a raw interrupt flag. The flag then waits for software to clear it by writing a one. Software can read the live count back, so time elapsed within a period is the period minus the value read, in clocks. At a 100 MHz clock, a period of 1000000 gives a 100 Hz tick.

A mask register gates the raw flag onto a registered interrupt output and a masked status register. A free-running timestamp counter sits alongside. It advances every clock and never stops. The register file is reached through a simple strobe bus. Reads return data one clock after the read strobe.

Register map (word addresses): 0 period (read/write), 1 control (write: bits[1:0] 01 load, 10 run, 11 stop, 00 no action; read: bit0 = running), 2 live count (read-only), 3 mask (bit0, read/write), 4 masked status (bit0, read-only), 5 raw flag (bit0, read-only), 6 acknowledge (write bit0 = 1 clears the raw flag, reads 0), 7 timestamp (read-only).

Top module: `tick_timer`

## Requirements
- R1: After reset the counter is stopped. The period, count, mask, raw flag, masked status and interrupt output are all zero.
- R2: A control write of 01 (load) copies the period register into the count and does not change the running state. While stopped, the count holds its value. A control write of 11 (stop) freezes the count.
- R3: After a control write of 10 (run) sampled at clock edge P, the count drops by one at each later edge. A read sampled at P+2 returns the period minus one, and the control register reads 1.
- R4: A running count at 1 (or 0) reloads from the period register at the next edge instead of reaching zero, and sets the raw flag at that same edge. With period D, expiries are D clocks apart, and the first expiry falls D edges after the run edge.
- R5: A period write made while running does not change the period in progress. The new value sets the length of every period after the next reload.
- R6: The interrupt output is a register of raw flag AND mask, so it follows them by one clock. The masked status register reads raw AND mask.
- R7: Writing 1 to bit0 of the acknowledge register clears the raw flag. Writing 0 there has no effect.
- R8: If an acknowledge write and an expiry fall on the same edge, the raw flag stays set.
- R9: The timestamp register increases by exactly one on every clock after reset and wraps modulo 2^TS_W.
- R10: Read data appears one clock after the read strobe. Addresses 8 and above read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A wrong count or a wrong reload value shows up as a wrong spacing between interrupt rises. The error appears within one period and is measured exactly in clocks. A mishandled raw flag shows at once in the raw register read, two clocks after the ack write. This matters most when the ack lands on the same edge as an expiry. A mask path error shows on the interrupt pin one clock after the mask write. Counter stepping and a frozen count appear in readbacks spaced by a known number of clocks.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int RA_PERIOD = 0;
  localparam int RA_CTRL   = 1;
  localparam int RA_COUNT  = 2;
  localparam int RA_MASK   = 3;
  localparam int RA_STATUS = 4;
  localparam int RA_RAW    = 5;
  localparam int RA_ACK    = 6;
  localparam int RA_STAMP  = 7;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_LOAD = 2'b01,
    OP_RUN  = 2'b10,
    OP_STOP = 2'b11
  } tick_op_e;
endpackage

// File: rtl/tick_stamp_counter.sv
module tick_stamp_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] stamp_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q <= '0;
      armed_q <= 1'b0;
    end else begin
      stamp_q <= stamp_q + 1'b1;
      armed_q <= 1'b1;
    end
  end

  AST_STAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (stamp_q == TS_W'($past(stamp_q) + 1'b1))); // R9
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic             do_load,
  input  logic             do_run,
  input  logic             do_stop,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = running_q && (cnt_q <= ONE) && !do_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (do_load) begin
      cnt_q <= period;
    end else if (running_q) begin
      if (cnt_q <= ONE) cnt_q <= period;
      else              cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          running_q <= 1'b0;
    else if (do_run)  running_q <= 1'b1;
    else if (do_stop) running_q <= 1'b0;
  end

  AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!running_q && !do_load) |=> $stable(cnt_q)); // R2
  AST_EXPIRY_RELOADS: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == $past(period))); // R4
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic ack,
  input  logic mask_wr,
  input  logic mask_bit,
  output logic raw_q,
  output logic mask_q,
  output logic irq_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q   <= 1'b0;
      mask_q  <= 1'b0;
      irq_o   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (expire)   raw_q <= 1'b1;
      else if (ack) raw_q <= 1'b0;
      if (mask_wr)  mask_q <= mask_bit;
      irq_o   <= raw_q & mask_q;
      armed_q <= 1'b1;
    end
  end

  AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (raw_q && !ack) |=> raw_q); // R7
  AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (rst)
    expire |=> raw_q); // R8
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    (armed_q && irq_o) |-> $past(mask_q)); // R6
endmodule

// File: rtl/tick_bus_regs.sv
module tick_bus_regs
  import tick_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              running,
  input  logic              raw,
  input  logic              mask,
  input  logic [TS_W-1:0]   stamp,
  output logic [CNT_W-1:0]  period_q,
  output logic              do_load,
  output logic              do_run,
  output logic              do_stop,
  output logic              mask_wr,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  tick_op_e op;
  logic     ctrl_wr;

  assign op      = tick_op_e'(wdata[1:0]);
  assign ctrl_wr = wr_en && (addr == ADDR_W'(RA_CTRL));
  assign do_load = ctrl_wr && (op == OP_LOAD);
  assign do_run  = ctrl_wr && (op == OP_RUN);
  assign do_stop = ctrl_wr && (op == OP_STOP);
  assign mask_wr = wr_en && (addr == ADDR_W'(RA_MASK));
  assign ack     = wr_en && (addr == ADDR_W'(RA_ACK)) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst)
      period_q <= '0;
    else if (wr_en && (addr == ADDR_W'(RA_PERIOD)))
      period_q <= CNT_W'(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(RA_PERIOD): rdata <= DATA_W'(period_q);
        ADDR_W'(RA_CTRL):   rdata <= DATA_W'(running);
        ADDR_W'(RA_COUNT):  rdata <= DATA_W'(cnt);
        ADDR_W'(RA_MASK):   rdata <= DATA_W'(mask);
        ADDR_W'(RA_STATUS): rdata <= DATA_W'(raw & mask);
        ADDR_W'(RA_RAW):    rdata <= DATA_W'(raw);
        ADDR_W'(RA_STAMP):  rdata <= DATA_W'(stamp);
        default:            rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TS_W-1:0]  stamp_q;
  logic do_load, do_run, do_stop, mask_wr, ack;
  logic running_q, expire, raw_q, mask_q;

  tick_bus_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TS_W(TS_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt_q), .running(running_q), .raw(raw_q),
    .mask(mask_q), .stamp(stamp_q), .period_q(period_q),
    .do_load(do_load), .do_run(do_run), .do_stop(do_stop),
    .mask_wr(mask_wr), .ack(ack), .rdata(rdata)
  );

  tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .period(period_q), .do_load(do_load),
    .do_run(do_run), .do_stop(do_stop), .cnt_q(cnt_q),
    .running_q(running_q), .expire(expire)
  );

  tick_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .expire(expire), .ack(ack),
    .mask_wr(mask_wr), .mask_bit(wdata[0]), .raw_q(raw_q),
    .mask_q(mask_q), .irq_o(irq_o)
  );

  tick_stamp_counter #(.TS_W(TS_W)) u_stamp (
    .clk(clk), .rst(rst), .stamp_q(stamp_q)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_o && (rdata == '0))); // R1
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic          rd_chk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq_o;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb[$];

  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  int  nr = 0;
  int  rises[16];
  logic pend_q = 1'b0;
  logic irq_prev = 1'b0;

  always #10 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    pend_q <= rd_en && rd_chk;
  end

  // monitor: pops the scoreboard one clock after each checked read
  always @(negedge clk) begin
    if (pend_q) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected read data", rdata, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rdata == it.exp, it.tag, rdata, it.exp);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && irq_o && !irq_prev && nr < 16) begin
      rises[nr] = cyc;
      nr++;
    end
    irq_prev = irq_o;
  end

  task automatic bus_wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected value, the monitor compares it
  task automatic bus_rd(input int a, input logic [DW-1:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_chk = 1'b1; addr = AW'(a);
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk);
    rd_en = 1'b0; rd_chk = 1'b0;
  endtask

  task automatic bus_peek(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [DW-1:0] v1, v2;
    int run_cyc;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check(irq_o == 1'b0, "R1 irq after reset", DW'(irq_o), 0);
    bus_rd(0, 0, "R1 period");
    bus_rd(1, 0, "R1 ctrl");
    bus_rd(2, 0, "R1 count");
    bus_rd(3, 0, "R1 mask");
    bus_rd(4, 0, "R1 status");
    bus_rd(5, 0, "R1 raw");
    bus_rd(6, 0, "R10 ack reads zero");
    bus_rd(10, 0, "R10 unmapped");

    // R2 load without run
    bus_wr(3, 1);
    bus_wr(0, 10);
    bus_rd(0, 10, "R2 period readback");
    bus_wr(1, 32'h1);
    bus_rd(2, 10, "R2 count after load");
    bus_rd(1, 0, "R2 load keeps stopped");
    bus_rd(2, 10, "R2 count held");

    // R3 run
    bus_wr(1, 32'h2);
    run_cyc = cyc;
    bus_rd(2, 9, "R3 count one step");
    bus_rd(1, 1, "R3 running");

    // R4 period spacing
    wait (nr >= 1);
    check(rises[0] - run_cyc == 11, "R4 first rise", DW'(rises[0] - run_cyc), 11);
    bus_wr(6, 1);
    bus_rd(5, 0, "R7 ack clears raw");
    check(irq_o == 1'b0, "R7 irq low after ack", DW'(irq_o), 0);
    wait (nr >= 2);
    bus_wr(6, 1);
    bus_wr(0, 6);  // R5 rewrite mid-period
    wait (nr >= 3);
    bus_wr(6, 1);
    wait (nr >= 4);
    bus_wr(6, 1);
    check(rises[1] - rises[0] == 10, "R4 period", DW'(rises[1] - rises[0]), 10);
    check(rises[2] - rises[1] == 10, "R5 old period kept", DW'(rises[2] - rises[1]), 10);
    check(rises[3] - rises[2] == 6, "R5 new period", DW'(rises[3] - rises[2]), 6);

    // R8 ack on the expiry edge
    wait (nr >= 5);
    check(rises[4] - rises[3] == 6, "R5 new period again", DW'(rises[4] - rises[3]), 6);
    repeat (3) @(negedge clk);
    bus_wr(6, 1);
    bus_rd(5, 1, "R8 expiry beats ack");

    // R2 stop freezes
    bus_wr(1, 32'h3);
    bus_peek(2, v1);
    bus_peek(2, v2);
    check(v1 == v2, "R2 stop freezes count", v2, v1);
    bus_rd(1, 0, "R2 stopped");

    // R6 masking
    bus_wr(3, 0);
    bus_rd(4, 0, "R6 status masked off");
    check(irq_o == 1'b0, "R6 irq masked off", DW'(irq_o), 0);
    bus_rd(5, 1, "R6 raw still set");
    bus_wr(6, 0);
    bus_rd(5, 1, "R7 zero ack ignored");
    bus_wr(3, 1);
    check(irq_o == 1'b0, "R6 irq one clock late", DW'(irq_o), 0);
    @(negedge clk);
    check(irq_o == 1'b1, "R6 irq follows mask", DW'(irq_o), 1);
    bus_rd(4, 1, "R6 status set");
    bus_wr(6, 1);
    bus_rd(5, 0, "R7 raw cleared");
    bus_rd(4, 0, "R6 status cleared");
    bus_rd(0, 6, "R5 period readback");

    // R9 timestamp
    bus_peek(7, v1);
    bus_peek(7, v2);
    check(v2 - v1 == 2, "R9 stamp step", v2 - v1, 2);
    repeat (5) @(negedge clk);
    bus_peek(7, v2);
    check(v2 - v1 == 9, "R9 stamp spaced", v2 - v1, 9);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R10 all reads answered", DW'(sb.size()), 0);
    finish_up();
  end
endmodule